// File: doc/BRIEF.md
# XOR-NAND Challenge Diffusion Grid

This block is the challenge–response core of a strong digital physical unclonable function. A rows×columns bit matrix, one bit per grid site, stands in for the per-chip random interconnect pattern. A bit is 1 where the link was formed and 0 where it is broken. An N-bit challenge, with N equal to the row count, enters on the left of the grid. Each column then rewrites every row bit. It does this by NAND-ing that site's link bit with a diagonal neighbour's bit from the previous column, and XOR-ing the result into the row's own previous bit. The bit after the last column is the response.

The grid itself is pure combinational logic. A two-state controller captures the grid's output into a response register on the clock edge where `start` is high. It then raises `valid` for the cycle that follows. The controller's states are `ST_IDLE` (no fresh response) and `ST_DONE` (response just captured, `valid` high). From either state, `start` leads to `ST_DONE` with a capture, and the absence of `start` leads to `ST_IDLE`. The register holds its value between captures.

Top module: `puf_diffusion_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `valid` is 0 and `response` is all zeros.
- R2: When `start` is high at a rising clock edge, `valid` is 1 in the next cycle, and `response` equals the grid output for the `challenge` and `link_map` present at that edge.
- R3: When `start` is low at a rising edge, `valid` is 0 in the next cycle, so a single `start` gives a one-cycle `valid` pulse.
- R4: Rows and columns are counted from 1. Challenge bit `challenge[i-1]` is row i's column-0 value, and `response[i-1]` is row i's value after column COLS. The link bit of row i, column j is `link_map[(j-1)*ROWS + (i-1)]`. In an odd column j, row i becomes NAND(link(i,j), row i-1 of column j-1) XOR row i of column j-1.
- R5: In an even column j, row i becomes NAND(link(i,j), row i+1 of column j-1) XOR row i of column j-1.
- R6: A neighbour row outside the grid (row 0 or row ROWS+1) reads as 0, so the top row in odd columns and the bottom row in even columns always XOR in a 1.
- R7: A broken link (bit 0) makes that site's NAND term 1 whatever the neighbour is. With an all-zero `link_map`, `response` is `challenge` inverted when COLS is odd and equal to `challenge` when COLS is even.
- R8: While `start` is low, `response` holds its value regardless of changes on `challenge` or `link_map`.
- R9: With `start` held high on consecutive edges, `valid` stays 1 and `response` takes a new capture each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture request for the current challenge and link matrix |
| challenge | input | ROWS | Challenge, bit i-1 enters row i |
| link_map | input | ROWS*COLS | Site link states, 1 = formed, 0 = broken |
| response | output | ROWS | Registered response |
| valid | output | 1 | One-cycle flag for a fresh response |

## Verification
Random challenges paired with random link matrices exercise the full recurrence. Any mistake in neighbour direction, column parity or bit placement shows up as a mismatch against the bench model. An all-broken matrix isolates the NAND-forcing rule: the outcome is a fixed inversion pattern that does not depend on the neighbours. An all-formed matrix makes every neighbour matter. Matrices with only odd or only even columns formed separate the two column rules. Single-bit challenges at the top and bottom rows expose edge handling, and changes to the inputs between starts show whether the register holds.

// File: rtl/puf_grid_pkg.sv
package puf_grid_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctrl_state_t;

endpackage

// File: rtl/diffusion_cell.sv
module diffusion_cell (
    input  logic link_ok,
    input  logic nbr_bit,
    input  logic own_bit,
    output logic out_bit
);

    logic nand_term;

    always_comb begin
        nand_term = ~(link_ok & nbr_bit);
        out_bit   = nand_term ^ own_bit;
    end

endmodule

// File: rtl/diffusion_column.sv
module diffusion_column #(
    parameter int ROWS    = 8,
    parameter bit ODD_COL = 1'b1
) (
    input  logic [ROWS-1:0] prev_bits,
    input  logic [ROWS-1:0] links,
    output logic [ROWS-1:0] next_bits
);

    logic [ROWS-1:0] nbr;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        if (ODD_COL) begin : g_up
            if (i == 0) begin : g_edge
                assign nbr[i] = 1'b0;
            end else begin : g_in
                assign nbr[i] = prev_bits[i-1];
            end
        end else begin : g_down
            if (i == ROWS - 1) begin : g_edge
                assign nbr[i] = 1'b0;
            end else begin : g_in
                assign nbr[i] = prev_bits[i+1];
            end
        end

        diffusion_cell u_cell (
            .link_ok (links[i]),
            .nbr_bit (nbr[i]),
            .own_bit (prev_bits[i]),
            .out_bit (next_bits[i])
        );
    end

endmodule

// File: rtl/diffusion_grid.sv
module diffusion_grid #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic [ROWS-1:0]      challenge,
    input  logic [ROWS*COLS-1:0] link_map,
    output logic [ROWS-1:0]      grid_out
);

    logic [ROWS-1:0] stage [0:COLS];

    assign stage[0] = challenge;

    for (genvar j = 0; j < COLS; j++) begin : g_col
        localparam bit IS_ODD = ((j + 1) % 2) == 1;

        diffusion_column #(
            .ROWS    (ROWS),
            .ODD_COL (IS_ODD)
        ) u_col (
            .prev_bits (stage[j]),
            .links     (link_map[j*ROWS +: ROWS]),
            .next_bits (stage[j+1])
        );
    end

    assign grid_out = stage[COLS];

endmodule

// File: rtl/puf_diffusion_top.sv
module puf_diffusion_top
    import puf_grid_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ROWS-1:0]      challenge,
    input  logic [ROWS*COLS-1:0] link_map,
    output logic [ROWS-1:0]      response,
    output logic                 valid
);

    ctrl_state_t     state_q;
    ctrl_state_t     state_d;
    logic [ROWS-1:0] grid_out;

    diffusion_grid #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_grid (
        .challenge (challenge),
        .link_map  (link_map),
        .grid_out  (grid_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            response <= '0;
        end else if (start) begin
            response <= grid_out;
        end
    end

    assign valid = (state_q == ST_DONE);

endmodule

// File: rtl/puf_diffusion_chk.sv
module puf_diffusion_chk #(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [ROWS-1:0]      challenge,
    input logic [ROWS*COLS-1:0] link_map,
    input logic [ROWS-1:0]      response,
    input logic                 valid
);

    localparam logic [ROWS-1:0] CLOSED_MASK = (COLS % 2 == 1) ? {ROWS{1'b1}} : {ROWS{1'b0}};

    // R2
    valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    // R3
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);

    // R8
    response_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(response));

    // R7
    all_broken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && link_map == '0) |=> (response == ($past(challenge) ^ CLOSED_MASK)));

endmodule

bind puf_diffusion_top puf_diffusion_chk #(
    .ROWS (ROWS),
    .COLS (COLS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .challenge (challenge),
    .link_map  (link_map),
    .response  (response),
    .valid     (valid)
);

// File: tb/tb_puf_diffusion_top.sv
module tb_puf_diffusion_top;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int NBIT = ROWS * COLS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [ROWS-1:0] challenge = '0;
    logic [NBIT-1:0] link_map = '0;
    logic [ROWS-1:0] response;
    logic            valid;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    puf_diffusion_top #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .challenge (challenge),
        .link_map  (link_map),
        .response  (response),
        .valid     (valid)
    );

    function automatic logic [ROWS-1:0] model(input logic [ROWS-1:0] ch, input logic [NBIT-1:0] mx);
        logic [ROWS-1:0] cur;
        logic [ROWS-1:0] nxt;
        logic            nb;
        cur = ch;
        for (int j = 1; j <= COLS; j++) begin
            for (int i = 1; i <= ROWS; i++) begin
                if (j % 2 == 1) nb = (i == 1) ? 1'b0 : cur[i-2];
                else            nb = (i == ROWS) ? 1'b0 : cur[i];
                nxt[i-1] = ~(mx[(j-1)*ROWS + (i-1)] & nb) ^ cur[i-1];
            end
            cur = nxt;
        end
        return cur;
    endfunction

    task automatic check(input string req, input logic [ROWS-1:0] act, input logic [ROWS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [ROWS-1:0] ch, input logic [NBIT-1:0] mx);
        logic [ROWS-1:0] exp;
        exp = model(ch, mx);
        @(negedge clk);
        challenge = ch;
        link_map  = mx;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R2 valid"}, {{(ROWS-1){1'b0}}, valid}, 1);
        check(req, response, exp);
        challenge = ~ch;
        link_map  = ~mx;
        @(negedge clk);
        check("R3 valid pulse", {{(ROWS-1){1'b0}}, valid}, 0);
        check("R8 hold", response, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        check("R1 reset response", response, '0);
        check("R1 reset valid", {{(ROWS-1){1'b0}}, valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", response, '0);
        check("R1 valid after reset", {{(ROWS-1){1'b0}}, valid}, 0);

        // R7: all broken, even column count returns the challenge unchanged
        run("R7 all broken", 8'hA5, '0);
        run("R7 all broken", 8'h3C, '0);
        check("R7 direct", response, 8'h3C);
        // all formed
        run("R4 all formed", 8'h00, '1);
        run("R5 all formed", 8'hFF, '1);
        // odd-only and even-only formed columns
        begin
            logic [NBIT-1:0] odd_m;
            odd_m = '0;
            for (int j = 0; j < COLS; j += 2) odd_m[j*ROWS +: ROWS] = '1;
            run("R4 odd columns", 8'h96, odd_m);
            run("R5 even columns", 8'h96, ~odd_m);
        end
        // R6 edge rows
        run("R6 top row", 8'h01, '1);
        run("R6 bottom row", 8'h80, '1);

        // R9 back to back
        @(negedge clk);
        challenge = 8'h5A; link_map = {$urandom(), $urandom()}; start = 1'b1;
        begin
            logic [ROWS-1:0] e1;
            logic [ROWS-1:0] e2;
            e1 = model(challenge, link_map);
            @(negedge clk);
            check("R9 first", response, e1);
            challenge = 8'hC3; link_map = {$urandom(), $urandom()};
            e2 = model(challenge, link_map);
            @(negedge clk);
            start = 1'b0;
            check("R9 valid held", {{(ROWS-1){1'b0}}, valid}, 1);
            check("R9 second", response, e2);
        end

        for (int k = 0; k < 200; k++) begin
            run("R4 R5 random", ROWS'($urandom()), {$urandom(), $urandom()});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule